// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block sits between a byte-wide host bus and three down-counting channel engines. The engines are outside this block. It decodes writes to a control port and to three data ports. From these writes it keeps each channel's operating mode, its byte-access order and its BCD flag. It assembles 16-bit initial counts from one or two byte writes and hands each finished count to its engine with a one-cycle load strobe. In the other direction it returns each channel's count a byte at a time. The count can come live from the engine, or from a snapshot taken by a latch command. A status byte can also be captured by a read-back command.

Address 3 is the control port. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. In a control byte, the field in bits 7:6 picks the channel, and the value 3 in that field turns the byte into a read-back command. The field in bits 5:4 picks the access order; the value 0 in that field requests a count snapshot instead. Each channel keeps three independent sequencers, and a status-valid flag takes priority over all of them:

- **Write sequencer:** states `SEQ_LOW` and `SEQ_HIGH`. A first data write in word order moves it from `SEQ_LOW` to `SEQ_HIGH`. The second write loads the count and moves it back to `SEQ_LOW`.
- **Read sequencer:** states `SEQ_LOW` and `SEQ_HIGH`. It toggles on each live read in word order.
- **Snapshot holder:** states `HOLD_NONE`, `HOLD_LO`, `HOLD_HI` and `HOLD_LOHI`.
  - A snapshot moves it from `HOLD_NONE` to the state that matches the access order.
  - A read takes it from `HOLD_LOHI` to `HOLD_HI`.
  - A read takes it from `HOLD_LO` or `HOLD_HI` back to `HOLD_NONE`.

Top module: `tmr_bus_frontend`

## Requirements
- R1: After reset, every channel reports mode 0, access order 3 (low byte then high byte) and binary counting. No snapshot or status is held, both sequencers are at the low byte, and no load strobe is raised.
- R2: A control write whose bits 7:6 name channel 0 to 2 and whose bits 5:4 are nonzero sets that channel's access order to bits 5:4, its mode to bits 3:1 and its BCD flag to bit 0. It returns both of that channel's sequencers to the low byte. Other channels are left unchanged.
- R3: In access order 1 (low only), a data write loads {8'h00, byte}. The load strobe of that channel rises for exactly one cycle, in the cycle after the write, and at most one strobe is high at a time.
- R4: In access order 2 (high only), a data write loads {byte, 8'h00}.
- R5: In access order 3, the first data write raises no strobe and is held. The second write loads {second byte, first byte}.
- R6: A control write with bits 5:4 equal to 0 captures the channel's live count. A further capture is ignored while that snapshot is still unread. The snapshot is returned in the access order and is released after the byte that completes that order.
- R7: With nothing captured, a read returns the live count. In order 1 it returns the low byte, in order 2 the high byte, and in order 3 the low and high bytes alternately.
- R8: A read-back command (bits 7:6 equal to 3) acts on channels 0, 1 and 2 when bits 1, 2 and 3 are set. It captures the count when bit 5 is 0 and the status when bit 4 is 0. The status byte is {output level, 1'b0, access order, mode, BCD}.
- R9: A data read returns the held status if there is one, otherwise the held count snapshot, otherwise the live count. The status is released by the read that returns it.
- R10: A held status is not replaced by a further read-back until it has been read.
- R11: A read-back command changes no channel's mode, access order or BCD flag.
- R12: `rdata` follows `addr` and the held state in the same cycle, without waiting for a clock. Address 3 reads as 8'h00. The read that `rd_en` performs advances the sequencers at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write in this cycle |
| rd_en | input | 1 | Bus read in this cycle |
| addr | input | 2 | 0 to 2 data port of a channel, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| live_count | input | 48 | Current count of each channel engine, channel 0 in bits 15:0 |
| out_level | input | 3 | Output level of each channel engine |
| ch_mode | output | 9 | Mode of each channel, 3 bits per channel |
| ch_access | output | 6 | Access order of each channel, 2 bits per channel |
| ch_bcd | output | 3 | BCD flag of each channel |
| load_value | output | 48 | Initial count for each channel, 16 bits per channel |
| load_strobe | output | 3 | One-cycle load pulse per channel |

## Verification
The results of this block fall due at different times.

- **`rdata`:** it is combinational, so the bench checks it one nanosecond after driving `addr` and `rd_en`, before the edge that consumes the read.
- **Load value and strobe:** these come from a register. The bench samples them at the falling edge that follows the write's rising edge, where the strobe is high for its single cycle.
- **Configuration and captured state:** mode, access order and captured state change at the write's rising edge. The bench reads them back through the ports after that edge.

Stimulus that must be ignored, such as a second capture, is always followed by reads that would expose an overwrite.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int NUM_CH = 3;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LSB   = 2'd1,
        ACC_MSB   = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        SEQ_LOW  = 1'b0,
        SEQ_HIGH = 1'b1
    } seq_e;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_LO   = 2'd1,
        HOLD_HI   = 2'd2,
        HOLD_LOHI = 2'd3
    } hold_e;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_bus_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:1]        cmd,
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] cnt_latch,
    output logic [NUM_CH-1:0] sts_latch,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic ctrl_wr;
    logic is_rb;
    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
    assign is_rb   = (cmd[7:6] == 2'b11);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic sel_ch;
        logic rb_sel;
        assign sel_ch       = ctrl_wr && !is_rb && (cmd[7:6] == 2'(i));
        assign rb_sel       = ctrl_wr && is_rb && cmd[i+1];
        assign cfg_we[i]    = sel_ch && (cmd[5:4] != 2'b00);
        assign cnt_latch[i] = (sel_ch && (cmd[5:4] == 2'b00)) || (rb_sel && !cmd[5]);
        assign sts_latch[i] = rb_sel && !cmd[4];
        assign data_we[i]   = wr_en && (addr == 2'(i));
        assign data_re[i]   = rd_en && (addr == 2'(i));
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cnt_latch,
    input  logic              sts_latch,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_level,
    output logic [MODE_W-1:0] mode,
    output logic [1:0]        access,
    output logic              bcd,
    output logic [CNT_W-1:0]  load_value,
    output logic              load_strobe,
    output logic [BYTE_W-1:0] rd_byte
);
    acc_e              acc_q, acc_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic              bcd_q, bcd_d;
    seq_e              wr_seq_q, wr_seq_d;
    seq_e              rd_seq_q, rd_seq_d;
    hold_e             hold_q, hold_d;
    logic [BYTE_W-1:0] wr_first_q, wr_first_d;
    logic [CNT_W-1:0]  cnt_snap_q, cnt_snap_d;
    logic              sts_valid_q, sts_valid_d;
    logic [BYTE_W-1:0] sts_byte_q, sts_byte_d;
    logic [CNT_W-1:0]  load_val_q, load_val_d;
    logic              load_stb_q, load_stb_d;

    // next-state logic for all sequencers
    always_comb begin
        acc_d       = acc_q;
        mode_d      = mode_q;
        bcd_d       = bcd_q;
        wr_seq_d    = wr_seq_q;
        rd_seq_d    = rd_seq_q;
        hold_d      = hold_q;
        wr_first_d  = wr_first_q;
        cnt_snap_d  = cnt_snap_q;
        sts_valid_d = sts_valid_q;
        sts_byte_d  = sts_byte_q;
        load_val_d  = load_val_q;
        load_stb_d  = 1'b0;

        // read consumption: status, then snapshot, then live sequence
        if (data_re) begin
            if (sts_valid_q) begin
                sts_valid_d = 1'b0;
            end else if (hold_q != HOLD_NONE) begin
                unique case (hold_q)
                    HOLD_LOHI: hold_d = HOLD_HI;
                    HOLD_LO:   hold_d = HOLD_NONE;
                    HOLD_HI:   hold_d = HOLD_NONE;
                    HOLD_NONE: hold_d = HOLD_NONE;
                endcase
            end else if (acc_q == ACC_WORD) begin
                rd_seq_d = (rd_seq_q == SEQ_LOW) ? SEQ_HIGH : SEQ_LOW;
            end
        end

        // count assembly
        if (data_we) begin
            unique case (acc_q)
                ACC_LSB: begin
                    load_val_d = {{BYTE_W{1'b0}}, wdata};
                    load_stb_d = 1'b1;
                end
                ACC_MSB: begin
                    load_val_d = {wdata, {BYTE_W{1'b0}}};
                    load_stb_d = 1'b1;
                end
                ACC_WORD: begin
                    unique case (wr_seq_q)
                        SEQ_LOW: begin
                            wr_first_d = wdata;
                            wr_seq_d   = SEQ_HIGH;
                        end
                        SEQ_HIGH: begin
                            load_val_d = {wdata, wr_first_q};
                            load_stb_d = 1'b1;
                            wr_seq_d   = SEQ_LOW;
                        end
                    endcase
                end
                ACC_LATCH: ;
            endcase
        end

        // snapshot capture, only into an empty holder
        if (cnt_latch && hold_q == HOLD_NONE) begin
            cnt_snap_d = live_count;
            unique case (acc_q)
                ACC_LSB:   hold_d = HOLD_LO;
                ACC_MSB:   hold_d = HOLD_HI;
                ACC_WORD:  hold_d = HOLD_LOHI;
                ACC_LATCH: hold_d = HOLD_NONE;
            endcase
        end

        if (sts_latch && !sts_valid_q) begin
            sts_valid_d = 1'b1;
            sts_byte_d  = {out_level, 1'b0, acc_q, mode_q, bcd_q};
        end

        if (cfg_we) begin
            acc_d    = acc_e'(wdata[5:4]);
            mode_d   = wdata[3:1];
            bcd_d    = wdata[0];
            wr_seq_d = SEQ_LOW;
            rd_seq_d = SEQ_LOW;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= ACC_WORD;
            mode_q      <= '0;
            bcd_q       <= 1'b0;
            wr_seq_q    <= SEQ_LOW;
            rd_seq_q    <= SEQ_LOW;
            hold_q      <= HOLD_NONE;
            wr_first_q  <= '0;
            cnt_snap_q  <= '0;
            sts_valid_q <= 1'b0;
            sts_byte_q  <= '0;
            load_val_q  <= '0;
            load_stb_q  <= 1'b0;
        end else begin
            acc_q       <= acc_d;
            mode_q      <= mode_d;
            bcd_q       <= bcd_d;
            wr_seq_q    <= wr_seq_d;
            rd_seq_q    <= rd_seq_d;
            hold_q      <= hold_d;
            wr_first_q  <= wr_first_d;
            cnt_snap_q  <= cnt_snap_d;
            sts_valid_q <= sts_valid_d;
            sts_byte_q  <= sts_byte_d;
            load_val_q  <= load_val_d;
            load_stb_q  <= load_stb_d;
        end
    end

    // outputs
    always_comb begin
        if (sts_valid_q) begin
            rd_byte = sts_byte_q;
        end else if (hold_q != HOLD_NONE) begin
            rd_byte = (hold_q == HOLD_HI) ? cnt_snap_q[CNT_W-1:BYTE_W] : cnt_snap_q[BYTE_W-1:0];
        end else begin
            unique case (acc_q)
                ACC_MSB:  rd_byte = live_count[CNT_W-1:BYTE_W];
                ACC_WORD: rd_byte = (rd_seq_q == SEQ_HIGH) ? live_count[CNT_W-1:BYTE_W]
                                                           : live_count[BYTE_W-1:0];
                ACC_LSB:  rd_byte = live_count[BYTE_W-1:0];
                ACC_LATCH: rd_byte = live_count[BYTE_W-1:0];
            endcase
        end
    end

    assign mode        = mode_q;
    assign access      = acc_q;
    assign bcd         = bcd_q;
    assign load_value  = load_val_q;
    assign load_strobe = load_stb_q;

    // R2: settings move only on a control word for this channel
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(mode_q) && $stable(acc_q) && $stable(bcd_q)));

    // R3: a strobe is always the result of a data write one cycle earlier
    a_r3_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_q |-> $past(data_we));

    // R5: the first byte of a word write loads nothing
    a_r5_first_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !cfg_we && acc_q == ACC_WORD && wr_seq_q == SEQ_LOW) |=> !load_stb_q);

    // R6: an unread snapshot is never replaced
    a_r6_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != HOLD_NONE && !data_re) |=> $stable(cnt_snap_q));

    // R10: an unread status stays valid and unchanged
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid_q && !data_re) |=> (sts_valid_q && $stable(sts_byte_q)));
endmodule

// File: rtl/tmr_bus_frontend.sv
module tmr_bus_frontend
    import tmr_bus_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_count,
    input  logic [NUM_CH-1:0]        out_level,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH*2-1:0]      ch_access,
    output logic [NUM_CH-1:0]        ch_bcd,
    output logic [NUM_CH*CNT_W-1:0]  load_value,
    output logic [NUM_CH-1:0]        load_strobe
);
    logic [NUM_CH-1:0] cfg_we, cnt_latch, sts_latch, data_we, data_re;
    logic [BYTE_W-1:0] rd_byte [NUM_CH];

    tmr_cmd_decode u_dec (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .cmd       (wdata[7:1]),
        .cfg_we    (cfg_we),
        .cnt_latch (cnt_latch),
        .sts_latch (sts_latch),
        .data_we   (data_we),
        .data_re   (data_re)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_chan_regs u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (cfg_we[i]),
            .cnt_latch   (cnt_latch[i]),
            .sts_latch   (sts_latch[i]),
            .data_we     (data_we[i]),
            .data_re     (data_re[i]),
            .wdata       (wdata),
            .live_count  (live_count[i*CNT_W +: CNT_W]),
            .out_level   (out_level[i]),
            .mode        (ch_mode[i*MODE_W +: MODE_W]),
            .access      (ch_access[i*2 +: 2]),
            .bcd         (ch_bcd[i]),
            .load_value  (load_value[i*CNT_W +: CNT_W]),
            .load_strobe (load_strobe[i]),
            .rd_byte     (rd_byte[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) rdata = rd_byte[i];
        end
    end

    // R3: never more than one channel loads at once
    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_strobe));

    // R11: read-back leaves every channel's settings alone
    a_r11_readback_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7:6] == 2'b11) |=>
        ($stable(ch_mode) && $stable(ch_access) && $stable(ch_bcd)));
endmodule

// File: tb/tmr_bus_frontend_tb_top.sv
module tmr_bus_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [47:0] live_count = {16'h5A6C, 16'hABCD, 16'h1234};
    logic [2:0]  out_level = 3'b101;
    logic [8:0]  ch_mode;
    logic [5:0]  ch_access;
    logic [2:0]  ch_bcd;
    logic [47:0] load_value;
    logic [2:0]  load_strobe;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    tmr_bus_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count), .out_level(out_level),
        .ch_mode(ch_mode), .ch_access(ch_access), .ch_bcd(ch_bcd),
        .load_value(load_value), .load_strobe(load_strobe)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LD = 2'd2, OP_NS = 2'd3;
    localparam int NV = 28;
    // {req[3:0], op, addr, data, expected}
    localparam logic [31:0] VEC [NV] = '{
        {4'd7,  OP_RD, 2'd0, 8'h00, 16'h0034}, // R7 word live low
        {4'd7,  OP_RD, 2'd0, 8'h00, 16'h0012}, // R7 word live high
        {4'd2,  OP_WR, 2'd3, 8'h10, 16'h0000}, // R2 ch0 low-only
        {4'd7,  OP_RD, 2'd0, 8'h00, 16'h0034}, // R7
        {4'd7,  OP_RD, 2'd0, 8'h00, 16'h0034}, // R7 no toggle
        {4'd3,  OP_WR, 2'd0, 8'h55, 16'h0000}, // R3
        {4'd3,  OP_LD, 2'd0, 8'h00, 16'h0055}, // R3
        {4'd2,  OP_WR, 2'd3, 8'h66, 16'h0000}, // R2 ch1 high-only mode 3
        {4'd4,  OP_WR, 2'd1, 8'h77, 16'h0000}, // R4
        {4'd4,  OP_LD, 2'd1, 8'h00, 16'h7700}, // R4
        {4'd7,  OP_RD, 2'd1, 8'h00, 16'h00AB}, // R7 high-only live
        {4'd2,  OP_WR, 2'd3, 8'hB4, 16'h0000}, // R2 ch2 word mode 2
        {4'd5,  OP_WR, 2'd2, 8'h11, 16'h0000}, // R5
        {4'd5,  OP_NS, 2'd2, 8'h00, 16'h0000}, // R5 no strobe
        {4'd5,  OP_WR, 2'd2, 8'h22, 16'h0000}, // R5
        {4'd5,  OP_LD, 2'd2, 8'h00, 16'h2211}, // R5
        {4'd8,  OP_WR, 2'd3, 8'hE2, 16'h0000}, // R8 status ch0
        {4'd8,  OP_RD, 2'd0, 8'h00, 16'h0090}, // R8 status byte
        {4'd9,  OP_RD, 2'd0, 8'h00, 16'h0034}, // R9 back to live
        {4'd2,  OP_WR, 2'd3, 8'h3B, 16'h0000}, // R2 ch0 word mode 5 bcd
        {4'd8,  OP_WR, 2'd3, 8'hE2, 16'h0000}, // R8
        {4'd8,  OP_RD, 2'd0, 8'h00, 16'h00BB}, // R8
        {4'd2,  OP_RD, 2'd0, 8'h00, 16'h0034}, // R2 read seq at low
        {4'd7,  OP_RD, 2'd0, 8'h00, 16'h0012}, // R7
        {4'd8,  OP_WR, 2'd3, 8'hE4, 16'h0000}, // R8 status ch1
        {4'd8,  OP_RD, 2'd1, 8'h00, 16'h0026}, // R8
        {4'd9,  OP_RD, 2'd1, 8'h00, 16'h00AB}, // R9
        {4'd12, OP_RD, 2'd3, 8'h00, 16'h0000}  // R12 control port reads zero
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(rdata == exp, req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_load(input int ch, input logic [15:0] exp, input string req);
        check(load_strobe == 3'(1 << ch), req, load_strobe, 1 << ch);
        check(load_value[ch*16 +: 16] == exp, req, load_value[ch*16 +: 16], exp);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ch_mode == 9'd0, "R1", ch_mode, 0);
        check(ch_access == 6'h3F, "R1", ch_access, 6'h3F);
        check(ch_bcd == 3'd0, "R1", ch_bcd, 0);
        check(load_strobe == 3'd0, "R1", load_strobe, 0);
        addr = 2'd1; #1;
        check(rdata == 8'hCD, "R1", rdata, 8'hCD);

        for (int k = 0; k < NV; k++) begin
            logic [31:0] v;
            string rq;
            v = VEC[k];
            rq = $sformatf("R%0d", v[31:28]);
            unique case (v[27:26])
                OP_WR: do_wr(v[25:24], v[23:16]);
                OP_RD: do_rd(v[25:24], v[7:0], rq);
                OP_LD: chk_load(int'(v[25:24]), v[15:0], rq);
                OP_NS: check(load_strobe == 3'd0, rq, load_strobe, 0);
            endcase
        end

        // R6 snapshot, second capture ignored
        do_wr(2'd3, 8'h30);
        do_wr(2'd3, 8'h00);
        live_count[15:0] = 16'h9999;
        do_wr(2'd3, 8'h00);
        do_rd(2'd0, 8'h34, "R6");
        do_rd(2'd0, 8'h12, "R6");
        do_rd(2'd0, 8'h99, "R6");

        // R9/R10 priority and status not overwritten
        do_wr(2'd3, 8'hC8);
        live_count[47:32] = 16'h0000;
        out_level = 3'b001;
        do_wr(2'd3, 8'hC8);
        do_rd(2'd2, 8'hB4, "R10");
        do_rd(2'd2, 8'h6C, "R9");
        do_rd(2'd2, 8'h5A, "R9");
        do_rd(2'd2, 8'h00, "R9");

        // R11 settings after read-backs; R2 per-channel isolation
        check(ch_mode == {3'd2, 3'd3, 3'd0}, "R11", ch_mode, {3'd2, 3'd3, 3'd0});
        check(ch_access == {2'd3, 2'd2, 2'd3}, "R11", ch_access, {2'd3, 2'd2, 2'd3});
        check(ch_bcd == 3'b000, "R2", ch_bcd, 0);

        // R2 control word restarts a half-done word write
        do_wr(2'd2, 8'h01);
        do_wr(2'd3, 8'hB4);
        do_wr(2'd2, 8'h03);
        check(load_strobe == 3'd0, "R2", load_strobe, 0);
        do_wr(2'd2, 8'h04);
        chk_load(2, 16'h0403, "R2");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule